// File: doc/BRIEF.md
# Soft Mute Envelope Sequencer

This block produces the gain envelope that fades an audio path into silence and back out again. A downstream multiplier or attenuator consumes a 10-bit coefficient: 0 means the signal passes and the all-ones code means full mute. When the control logic raises the mute request, the coefficient climbs along an S-shaped curve. The curve moves in small steps near both ends and in large steps in the middle, so the fade is gentle where it is most audible. Clearing the request runs the same curve back down to 0.

Three fade durations are available. With the default parameters at a 125 MHz clock they come to roughly half a millisecond, one millisecond and 123 ms. Once a fade has started it always finishes, whatever happens to the request or the duration select. The request is looked at again only after the fade completes.

A separate force input lets another function, such as an offset alignment step, slam the output to full mute at once. A status output tells the control bus that muting is in effect.

Top module: `soft_mute_seq`

## Requirements
- R1: After reset the envelope output is 0 and the status output is low.
- R2: A high mute request while the envelope rests at 0 starts a fade that raises the envelope monotonically to full mute, code 1023.
- R3: The envelope range is split into 8 segments of 128 codes by its top three bits. The step sizes for segments 0 to 7 are 1, 2, 4, 8, 8, 4, 2, 1. A rising step uses the segment of the current value and a falling step uses the segment of the value minus one, so a full fade in either direction takes exactly 479 steps.
- R4: One step happens every N clock cycles. N is DIV_SHORT for select 0, DIV_MID for select 1, and DIV_LONG for select 2 or 3. The select is sampled on the edge that starts a fade, and the end value appears 479*N edges after that edge.
- R5: Changes to the request or the select while a fade runs have no effect on its course or its duration. If the request differs from the end state when the fade completes, the opposite fade starts on the next edge.
- R6: The status output rises on the edge that starts a mute fade. It stays high through full mute and the whole release, and it falls on the edge where the envelope returns to 0.
- R7: While the force input is high, the envelope is 1023 and the status is high from the next edge on, even in the middle of a fade. After force drops with the request low, a normal release fade starts on the next edge.
- R8: A low request while at full mute starts a release that lowers the envelope monotonically to 0 with the curve of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mute_req | input | 1 | Mute request, 1 = mute |
| time_sel | input | 2 | Fade duration select |
| force_mute | input | 1 | Immediate hard mute |
| env | output | 10 | Envelope coefficient, 0 = pass, 1023 = full mute |
| mute_active | output | 1 | Mute in effect |

## Verification
The hardest situation to reach from the ports is a request reversal in the middle of a fade. The request must flip while the envelope is part-way up, and the bench must then show that the fade still reaches its end on the original schedule before turning around. The bench drops the request and changes the select a hundred cycles into a rise. It then measures the total rise time against the originally sampled select, and the following release time against the new one. The force override is aimed at the middle of a release in the same way.

// File: rtl/soft_mute_seq.sv
module soft_mute_seq #(
  parameter int ENV_W     = 10,
  parameter int DIV_SHORT = 125,
  parameter int DIV_MID   = 250,
  parameter int DIV_LONG  = 32098
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mute_req,
  input  logic [1:0]       time_sel,
  input  logic             force_mute,
  output logic [ENV_W-1:0] env,
  output logic             mute_active
);
  localparam int DMAX = (DIV_LONG > DIV_MID) ? ((DIV_LONG > DIV_SHORT) ? DIV_LONG : DIV_SHORT)
                                             : ((DIV_MID > DIV_SHORT) ? DIV_MID : DIV_SHORT);
  localparam int DIV_W = $clog2(DMAX) + 1;
  localparam logic [ENV_W-1:0] FULL = '1;

  typedef enum logic [1:0] {S_OPEN, S_MUTING, S_MUTED, S_RELEASE} st_t;

  st_t              state;
  logic [1:0]       sel_q;
  logic [DIV_W-1:0] tick, lim;
  logic [2:0]       seg_up, seg_dn;
  logic [ENV_W-1:0] step, nxt_up, nxt_dn;
  logic             tick_last;

  function automatic logic [ENV_W-1:0] seg_step(input logic [2:0] s);
    case (s)
      3'd0, 3'd7: seg_step = ENV_W'(1);
      3'd1, 3'd6: seg_step = ENV_W'(2);
      3'd2, 3'd5: seg_step = ENV_W'(4);
      default:    seg_step = ENV_W'(8);
    endcase
  endfunction

  assign lim       = (sel_q == 2'd0) ? DIV_W'(DIV_SHORT) :
                     (sel_q == 2'd1) ? DIV_W'(DIV_MID) : DIV_W'(DIV_LONG);
  assign tick_last = (tick == lim - DIV_W'(1));
  assign seg_up    = env[ENV_W-1 -: 3];
  assign seg_dn    = 3'((env - ENV_W'(1)) >> (ENV_W - 3));
  assign step      = seg_step((state == S_RELEASE) ? seg_dn : seg_up);
  assign nxt_up    = env + step;
  assign nxt_dn    = env - step;
  assign mute_active = (state != S_OPEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_OPEN;
      env   <= '0;
      tick  <= '0;
      sel_q <= 2'd0;
    end else if (force_mute) begin
      state <= S_MUTED;
      env   <= FULL;
      tick  <= '0;
    end else begin
      case (state)
        S_OPEN: if (mute_req) begin
          state <= S_MUTING;
          tick  <= '0;
          sel_q <= time_sel;
        end
        S_MUTED: if (!mute_req) begin
          state <= S_RELEASE;
          tick  <= '0;
          sel_q <= time_sel;
        end
        S_MUTING: if (tick_last) begin
          tick <= '0;
          env  <= nxt_up;
          if (nxt_up == FULL) state <= S_MUTED;
        end else begin
          tick <= tick + DIV_W'(1);
        end
        default: if (tick_last) begin
          tick <= '0;
          env  <= nxt_dn;
          if (nxt_dn == '0) state <= S_OPEN;
        end else begin
          tick <= tick + DIV_W'(1);
        end
      endcase
    end
  end

  p_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MUTING && !force_mute) |=> (env >= $past(env)));

  p_step_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MUTING && !force_mute) |=> ((env - $past(env)) <= ENV_W'(8)));

  p_no_reverse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MUTING && !force_mute) |=> (state == S_MUTING || state == S_MUTED));

  p_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (env != '0) |-> mute_active);

  p_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    force_mute |=> (env == FULL && mute_active));

  p_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RELEASE && !force_mute) |=> (env <= $past(env)));
endmodule

// File: tb/soft_mute_seq_tb.sv
`timescale 1ns/1ps
module soft_mute_seq_tb;
  localparam int D0 = 3, D1 = 5, D2 = 7;
  localparam int STEPS = 479;

  logic clk = 0, rst_n = 0, mute_req = 0, force_mute = 0;
  logic [1:0] time_sel = 0;
  logic [9:0] env;
  logic mute_active;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  soft_mute_seq #(.ENV_W(10), .DIV_SHORT(D0), .DIV_MID(D1), .DIV_LONG(D2)) u_dut (
    .clk(clk), .rst_n(rst_n), .mute_req(mute_req), .time_sel(time_sel),
    .force_mute(force_mute), .env(env), .mute_active(mute_active));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int div_of(input logic [1:0] s);
    return (s == 0) ? D0 : (s == 1) ? D1 : D2;
  endfunction

  task automatic wait_env(input logic [9:0] tgt, output int n, output int bad_status);
    n = 0; bad_status = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
      if (env != tgt && !mute_active) bad_status++;
    end while (env != tgt && n < 40000);
  endtask

  task automatic t_reset;
    chk(env == 0, "R1 env", env, 0);
    chk(mute_active == 0, "R1 status", mute_active, 0);
  endtask

  task automatic t_mute(input logic [1:0] s);
    int n, bad;
    time_sel = s; mute_req = 1;
    @(posedge clk); @(negedge clk);
    chk(mute_active == 1, "R6 status rises at start", mute_active, 1);
    chk(env == 0, "R4 no step yet", env, 0);
    time_sel = ~s;
    wait_env(10'd1023, n, bad);
    chk(n + 1 == 1 + STEPS * div_of(s), "R4 R2 mute duration", n + 1, 1 + STEPS * div_of(s));
    chk(mute_active == 1, "R6 status at full mute", mute_active, 1);
  endtask

  task automatic t_release(input logic [1:0] s);
    int n, bad;
    time_sel = s; mute_req = 0;
    wait_env(10'd0, n, bad);
    chk(n == 1 + STEPS * div_of(s), "R8 release duration", n, 1 + STEPS * div_of(s));
    chk(bad == 0, "R6 status high during release", bad, 0);
    chk(mute_active == 0, "R6 status falls at 0", mute_active, 0);
  endtask

  task automatic t_shape;
    int prev, cnt, d_first, d_mid, d_last, dn_first, dn_mid;
    time_sel = 0; mute_req = 1; prev = 0; cnt = 0;
    d_first = -1; d_mid = -1; d_last = -1;
    while (env != 1023 && cnt < 600) begin
      @(negedge clk);
      if (env != prev) begin
        if (prev == 0) d_first = env - prev;
        if (prev == 512) d_mid = env - prev;
        if (env == 1023) d_last = env - prev;
        cnt++; prev = env;
      end
    end
    chk(cnt == STEPS, "R3 rise step count", cnt, STEPS);
    chk(d_first == 1, "R3 first rise step", d_first, 1);
    chk(d_mid == 8, "R3 middle rise step", d_mid, 8);
    chk(d_last == 1, "R3 last rise step", d_last, 1);
    mute_req = 0; cnt = 0; dn_first = -1; dn_mid = -1;
    while (env != 0 && cnt < 600) begin
      @(negedge clk);
      if (env != prev) begin
        if (prev == 1023) dn_first = prev - env;
        if (prev == 512) dn_mid = prev - env;
        cnt++; prev = env;
      end
    end
    chk(cnt == STEPS, "R3 fall step count", cnt, STEPS);
    chk(dn_first == 1, "R3 first fall step", dn_first, 1);
    chk(dn_mid == 8, "R3 middle fall step", dn_mid, 8);
  endtask

  task automatic t_no_interrupt;
    int n, bad;
    time_sel = 1; mute_req = 1;
    repeat (100) @(negedge clk);
    chk(env != 0 && env != 1023, "R5 mid-fade", env, 500);
    mute_req = 0; time_sel = 0;
    wait_env(10'd1023, n, bad);
    chk(100 + n == 1 + STEPS * D1, "R5 fade completes on original schedule", 100 + n, 1 + STEPS * D1);
    wait_env(10'd0, n, bad);
    chk(n == 1 + STEPS * D0, "R5 opposite fade follows with new select", n, 1 + STEPS * D0);
  endtask

  task automatic t_force;
    int n, bad;
    force_mute = 1;
    @(posedge clk); @(negedge clk);
    chk(env == 1023 && mute_active, "R7 force from pass", env, 1023);
    force_mute = 0; mute_req = 0; time_sel = 0;
    repeat (300) @(negedge clk);
    chk(env != 0 && env != 1023, "R7 release under way", env, 500);
    force_mute = 1;
    @(posedge clk); @(negedge clk);
    chk(env == 1023 && mute_active, "R7 force mid-release", env, 1023);
    repeat (5) @(negedge clk);
    chk(env == 1023, "R7 held while forced", env, 1023);
    force_mute = 0;
    wait_env(10'd0, n, bad);
    chk(n == 1 + STEPS * D0, "R7 soft release after force", n, 1 + STEPS * D0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_mute(2'd0); t_release(2'd0);
    t_mute(2'd1); t_release(2'd2);
    t_mute(2'd3); t_release(2'd1);
    t_shape;
    t_no_interrupt;
    t_force;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule